// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns parallel audio words into the serial data line of an I2S link. The bit clock and word select come from outside: the block receives a one-cycle `bitTick` strobe for each bit period and samples `wsIn` on that strobe. A change in the sampled word select starts a slot: word select low is the left channel and high is the right channel. The new sample is loaded on that tick. Its most significant bit appears on `sdo` at the next tick, and the remaining bits follow MSB first.

Words arrive over valid/ready streams. One mode uses a single shared stream that carries left and right words in turn. The other uses a separate stream for each channel. A three-bit length code selects the sample width and the two packed stereo formats. Mono mode repeats the left sample in the right slot. When a slot starts and no word is available, the block sends either silence or that channel's previous sample, and it raises a sticky underrun flag.

Configuration inputs must stay constant while `en` is high. Driving `en` low stops the serializer and clears its state.

Top module: `i2s_tx_ser`

## Requirements
- R1: After reset, `sdo`, `aReady`, `bReady` and `underrun` are 0.
- R2: A slot starts at the tick where the sampled `wsIn` differs from its value at the previous tick (0 = left, 1 = right). The sample's MSB is on `sdo` after the following tick. The other bits follow MSB first, one per tick, and the last bit of the slot is output at the tick where the next slot starts. Slot bits after the sample length are 0.
- R3: The length code selects the width of the sample, which is taken from the low bits of the word: 0 = 32, 1 = 24, 2 = 20, 3 = 18, 4 = 16, 6 = 8 bits. Word bits above the sample are ignored.
- R4: With code 5, each left slot takes one word. Bits 15:0 form the left sample and bits 31:16 the right sample, each 16 bits wide. The right slot takes no word.
- R5: With code 7, each left slot takes one word. Bits 7:0 form the left sample and bits 15:8 the right sample, each 8 bits wide.
- R6: With `monoEn` = 1, the right slot carries the sample of the preceding left slot and takes no word.
- R7: With `perChanEn` = 0 and a non-packed code, left and right slots each take the next word from stream A, in turn.
- R8: With `perChanEn` = 1, left words come from stream A and right words from stream B. `bReady` is never 1 while `perChanEn` = 0.
- R9: If a slot that needs a word finds its stream not valid and `repeatOnUnderrun` = 0, the slot carries all zeros.
- R10: If such a slot occurs with `repeatOnUnderrun` = 1, the slot carries the last sample that stream data supplied to the same channel.
- R11: Every underrun sets `underrun`, and it stays set until a `clrUnderrun` pulse in a cycle with no new underrun.
- R12: A ready output is 1 only during a slot-start tick while `en` = 1, and each handshake consumes one word. While `en` = 0, `sdo` is 0, no word is taken and the stored samples are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low stops and clears the serializer |
| bitTick | input | 1 | One-cycle strobe per serial bit period |
| wsIn | input | 1 | Word select, sampled on `bitTick` |
| lenCode | input | 3 | Sample length / packing code |
| monoEn | input | 1 | Repeat the left sample in the right slot |
| perChanEn | input | 1 | Use one input stream per channel |
| repeatOnUnderrun | input | 1 | On underrun, resend the previous sample instead of zeros |
| clrUnderrun | input | 1 | Clears the sticky underrun flag |
| aData | input | 32 | Stream A word (shared stream or left channel) |
| aValid | input | 1 | Stream A word valid |
| aReady | output | 1 | Stream A word taken this cycle |
| bData | input | 32 | Stream B word (right channel) |
| bValid | input | 1 | Stream B word valid |
| bReady | output | 1 | Stream B word taken this cycle |
| sdo | output | 1 | Serial data out |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The assertions assume that `bitTick` is a single-cycle strobe and that the configuration inputs stay constant while `en` is high. They also assume that ready is judged in the same cycle as valid, because the handshake is combinational at slot start. The stimulus respects these assumptions. Between ticks it waits at least one idle cycle, and it changes configuration only while `en` is low. It updates valid and data only on the falling clock edge after an accepted handshake, and it toggles word select once every 32 ticks.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 3;
  localparam logic [LEN_W-1:0] LEN_PACK16 = 3'd5;
  localparam logic [LEN_W-1:0] LEN_PACK8  = 3'd7;

  typedef enum logic [2:0] {
    SEL_FRESH,
    SEL_HELD,
    SEL_FRAME_LEFT,
    SEL_PREV,
    SEL_ZERO
  } sampleSel_e;

  typedef struct packed {
    logic       shift;
    logic       load;
    logic       rightSlot;
    sampleSel_e sel;
    logic       fromB;
    logic       keepHigh;
    logic       wipe;
  } strobe_t;

  function automatic logic isPacked(input logic [LEN_W-1:0] code);
    return (code == LEN_PACK16) || (code == LEN_PACK8);
  endfunction

  // First (or only) sample of a word, moved to the top of the slot register
  function automatic logic [WORD_W-1:0] alignLow(input logic [WORD_W-1:0] w,
                                                 input logic [LEN_W-1:0] code);
    case (code)
      3'd0:      return w;
      3'd1:      return {w[23:0], 8'h00};
      3'd2:      return {w[19:0], 12'h000};
      3'd3:      return {w[17:0], 14'h0000};
      3'd4, 3'd5: return {w[15:0], 16'h0000};
      default:   return {w[7:0], 24'h000000};
    endcase
  endfunction

  // Second sample of a packed word
  function automatic logic [WORD_W-1:0] alignHigh(input logic [WORD_W-1:0] w,
                                                  input logic [LEN_W-1:0] code);
    case (code)
      LEN_PACK16: return {w[31:16], 16'h0000};
      LEN_PACK8:  return {w[15:8], 24'h000000};
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             bitTick,
  input  logic             wsIn,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             monoEn,
  input  logic             perChanEn,
  input  logic             repeatOnUnderrun,
  input  logic             clrUnderrun,
  input  logic             aValid,
  input  logic             bValid,
  output logic             aReady,
  output logic             bReady,
  output logic             underrun,
  output strobe_t          strb
);
  logic       wsPrev;
  logic       bufHeld;
  logic       flagQ;
  logic       starve;
  logic       slotStart, leftStart, rightStart, packedMode;
  sampleSel_e selD;
  logic       fromBD, keepHighD;

  assign slotStart  = en && bitTick && (wsIn != wsPrev);
  assign leftStart  = slotStart && !wsIn;
  assign rightStart = slotStart && wsIn;
  assign packedMode = isPacked(lenCode);

  always_ff @(posedge clk) begin
    if (!rstN || !en)  wsPrev <= 1'b1;
    else if (bitTick)  wsPrev <= wsIn;
  end

  always_comb begin
    aReady    = 1'b0;
    bReady    = 1'b0;
    starve    = 1'b0;
    selD      = SEL_ZERO;
    fromBD    = 1'b0;
    keepHighD = 1'b0;
    if (leftStart) begin
      aReady = 1'b1;
      if (aValid) begin
        selD      = SEL_FRESH;
        keepHighD = packedMode;
      end else begin
        starve = 1'b1;
      end
    end else if (rightStart) begin
      if (monoEn) begin
        selD = SEL_FRAME_LEFT;
      end else if (packedMode) begin
        if (bufHeld) selD = SEL_HELD;
        else         starve = 1'b1;
      end else if (perChanEn) begin
        bReady = 1'b1;
        fromBD = 1'b1;
        if (bValid) selD = SEL_FRESH;
        else        starve = 1'b1;
      end else begin
        aReady = 1'b1;
        if (aValid) selD = SEL_FRESH;
        else        starve = 1'b1;
      end
    end
    if (starve) selD = repeatOnUnderrun ? SEL_PREV : SEL_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !en)    bufHeld <= 1'b0;
    else if (leftStart)  bufHeld <= aValid && packedMode;
    else if (rightStart) bufHeld <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            flagQ <= 1'b0;
    else if (starve)      flagQ <= 1'b1;
    else if (clrUnderrun) flagQ <= 1'b0;
  end

  assign underrun       = flagQ;
  assign strb.shift     = en && bitTick;
  assign strb.load      = slotStart;
  assign strb.rightSlot = wsIn;
  assign strb.sel       = selD;
  assign strb.fromB     = fromBD;
  assign strb.keepHigh  = keepHighD;
  assign strb.wipe      = !en;

  a_r8_b_idle: assert property (@(posedge clk) disable iff (!rstN)
    !perChanEn |-> !bReady);
  a_r12_ready_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (aReady || bReady) |-> (bitTick && en));
  a_r12_one_ready: assert property (@(posedge clk) disable iff (!rstN)
    !(aReady && bReady));
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !clrUnderrun) |=> underrun);
  a_r6_mono_right_no_take: assert property (@(posedge clk) disable iff (!rstN)
    (monoEn && wsIn) |-> (!aReady && !bReady));
endmodule

// File: rtl/i2s_tx_dpath.sv
module i2s_tx_dpath
  import i2s_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [LEN_W-1:0]  lenCode,
  input  logic [WORD_W-1:0] aData,
  input  logic [WORD_W-1:0] bData,
  output logic              sdo
);
  logic [WORD_W-1:0] word, lowAl, highAl, chosen;
  logic [WORD_W-1:0] shReg, heldR, frameLeft, prevL, prevR;
  logic              sdoQ;

  assign word   = strb.fromB ? bData : aData;
  assign lowAl  = alignLow(word, lenCode);
  assign highAl = alignHigh(word, lenCode);

  always_comb begin
    case (strb.sel)
      SEL_FRESH:      chosen = lowAl;
      SEL_HELD:       chosen = heldR;
      SEL_FRAME_LEFT: chosen = frameLeft;
      SEL_PREV:       chosen = strb.rightSlot ? prevR : prevL;
      default:        chosen = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.wipe) begin
      shReg     <= '0;
      sdoQ      <= 1'b0;
      heldR     <= '0;
      frameLeft <= '0;
      prevL     <= '0;
      prevR     <= '0;
    end else begin
      if (strb.keepHigh) heldR <= highAl;
      if (strb.load && !strb.rightSlot) frameLeft <= chosen;
      if (strb.load && strb.sel == SEL_FRESH) begin
        if (strb.rightSlot) prevR <= chosen;
        else                prevL <= chosen;
      end
      if (strb.load && strb.sel == SEL_HELD) prevR <= chosen;
      if (strb.shift) begin
        sdoQ  <= shReg[WORD_W-1];
        shReg <= strb.load ? chosen : {shReg[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign sdo = sdoQ;

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.shift && !strb.wipe) |=> $stable(sdo));
  a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipe |=> !sdo);
  a_r2_load_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> strb.shift);
endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
  import i2s_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic              bitTick,
  input  logic              wsIn,
  input  logic [LEN_W-1:0]  lenCode,
  input  logic              monoEn,
  input  logic              perChanEn,
  input  logic              repeatOnUnderrun,
  input  logic              clrUnderrun,
  input  logic [WORD_W-1:0] aData,
  input  logic              aValid,
  output logic              aReady,
  input  logic [WORD_W-1:0] bData,
  input  logic              bValid,
  output logic              bReady,
  output logic              sdo,
  output logic              underrun
);
  strobe_t strb;

  i2s_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .en(en), .bitTick(bitTick), .wsIn(wsIn),
    .lenCode(lenCode), .monoEn(monoEn), .perChanEn(perChanEn),
    .repeatOnUnderrun(repeatOnUnderrun), .clrUnderrun(clrUnderrun),
    .aValid(aValid), .bValid(bValid), .aReady(aReady), .bReady(bReady),
    .underrun(underrun), .strb(strb)
  );

  i2s_tx_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .lenCode(lenCode),
    .aData(aData), .bData(bData), .sdo(sdo)
  );
endmodule

// File: tb/i2s_tx_ser_tb.sv
`timescale 1ns/1ps
module i2s_tx_ser_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0, bitTick = 1'b0, wsIn = 1'b1;
  logic [2:0] lenCode = 3'd0;
  logic monoEn = 1'b0, perChanEn = 1'b0, repeatOnUnderrun = 1'b0, clrUnderrun = 1'b0;
  logic [31:0] aData = '0, bData = '0;
  logic aValid = 1'b0, bValid = 1'b0;
  logic aReady, bReady, sdo, underrun;

  int tests = 0, fails = 0;
  logic [31:0] aQ[$], bQ[$];
  logic [31:0] capL[0:7], capR[0:7], expL[0:7], expR[0:7];
  logic lastBit, flagPre, badB, badIdle, sawTake;

  always #4 clk = ~clk;

  i2s_tx_ser u_dut (
    .clk(clk), .rstN(rstN), .en(en), .bitTick(bitTick), .wsIn(wsIn),
    .lenCode(lenCode), .monoEn(monoEn), .perChanEn(perChanEn),
    .repeatOnUnderrun(repeatOnUnderrun), .clrUnderrun(clrUnderrun),
    .aData(aData), .aValid(aValid), .aReady(aReady),
    .bData(bData), .bValid(bValid), .bReady(bReady),
    .sdo(sdo), .underrun(underrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expSample(input logic [2:0] c, input logic [31:0] w);
    int len;
    logic [63:0] m;
    case (c)
      3'd0: len = 32;
      3'd1: len = 24;
      3'd2: len = 20;
      3'd3: len = 18;
      3'd4, 3'd5: len = 16;
      default: len = 8;
    endcase
    m = (64'd1 << len) - 64'd1;
    return 32'(({32'd0, w} & m) << (32 - len));
  endfunction

  task automatic refresh();
    aValid = (aQ.size() != 0);
    aData  = aValid ? aQ[0] : 32'h0;
    bValid = (bQ.size() != 0);
    bData  = bValid ? bQ[0] : 32'h0;
  endtask

  task automatic doTick(input logic wsV);
    logic takeA, takeB;
    @(negedge clk);
    wsIn = wsV;
    bitTick = 1'b1;
    #1;
    takeA = aReady && aValid;
    takeB = bReady && bValid;
    if (!perChanEn && bReady) badB = 1'b1;
    if (takeA || takeB) sawTake = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bitTick = 1'b0;
    if (takeA) void'(aQ.pop_front());
    if (takeB) void'(bQ.pop_front());
    refresh();
    #1;
    if (aReady || bReady) badIdle = 1'b1;
    lastBit = sdo;
  endtask

  task automatic runFrames(input int n);
    for (int g = 0; g <= 64 * n; g++) begin
      int j = g % 64;
      int f = g / 64;
      logic w = (g == 64 * n) ? 1'b0 : ((j < 32) ? 1'b0 : 1'b1);
      if (g == 64 * n) flagPre = underrun;
      doTick(w);
      if (g >= 1) begin
        if (j >= 1 && j <= 32) capL[f][32 - j] = lastBit;
        else if (j > 32)       capR[f][64 - j] = lastBit;
        else                   capR[f - 1][0] = lastBit;
      end
    end
  endtask

  task automatic startTest(input logic [2:0] code, input logic mono, input logic perChan,
                           input logic rep);
    en = 1'b0;
    wsIn = 1'b1;
    repeat (2) @(negedge clk);
    lenCode = code;
    monoEn = mono;
    perChanEn = perChan;
    repeatOnUnderrun = rep;
    clrUnderrun = 1'b1;
    @(negedge clk);
    clrUnderrun = 1'b0;
    refresh();
    en = 1'b1;
  endtask

  task automatic cmpFrames(input int n, input string req);
    for (int f = 0; f < n; f++) begin
      check({req, " left slot"}, capL[f], expL[f]);
      check({req, " right slot"}, capR[f], expR[f]);
    end
  endtask

  task automatic t_reset();
    check("R1 sdo", {31'd0, sdo}, 32'd0);
    check("R1 ready", {30'd0, aReady, bReady}, 32'd0);
    check("R1 underrun", {31'd0, underrun}, 32'd0);
  endtask

  task automatic t_stereo32();
    badB = 1'b0; badIdle = 1'b0;
    aQ = {32'h8123_4567, 32'h0F1E_2D3C, 32'hC001_D00D, 32'h1357_9BDF};
    startTest(3'd0, 1'b0, 1'b0, 1'b0);
    runFrames(2);
    expL[0] = 32'h8123_4567; expR[0] = 32'h0F1E_2D3C;
    expL[1] = 32'hC001_D00D; expR[1] = 32'h1357_9BDF;
    cmpFrames(2, "R7 R2 shared stream 32-bit");
    check("R11 no underrun with data", {31'd0, flagPre}, 32'd0);
    check("R8 bReady idle when not per-channel", {31'd0, badB}, 32'd0);
    check("R12 ready only at slot start", {31'd0, badIdle}, 32'd0);
  endtask

  task automatic t_lengths();
    logic [2:0] codes[5] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd6};
    for (int k = 0; k < 5; k++) begin
      aQ = {32'hF0E1_D2C3, 32'h8B7A_6958};
      startTest(codes[k], 1'b0, 1'b0, 1'b0);
      runFrames(1);
      expL[0] = expSample(codes[k], 32'hF0E1_D2C3);
      expR[0] = expSample(codes[k], 32'h8B7A_6958);
      cmpFrames(1, $sformatf("R3 R2 length code %0d", codes[k]));
    end
  endtask

  task automatic t_pack16();
    aQ = {32'hBEEF_1234, 32'h7654_A987};
    startTest(3'd5, 1'b0, 1'b0, 1'b0);
    runFrames(2);
    expL[0] = 32'h1234_0000; expR[0] = 32'hBEEF_0000;
    expL[1] = 32'hA987_0000; expR[1] = 32'h7654_0000;
    cmpFrames(2, "R4 packed 16-bit");
    check("R4 one word per frame", {31'd0, flagPre}, 32'd0);
  endtask

  task automatic t_pack8();
    aQ = {32'h1122_C33C, 32'h0000_7E81};
    startTest(3'd7, 1'b0, 1'b0, 1'b0);
    runFrames(2);
    expL[0] = 32'h3C00_0000; expR[0] = 32'hC300_0000;
    expL[1] = 32'h8100_0000; expR[1] = 32'h7E00_0000;
    cmpFrames(2, "R5 packed 8-bit");
  endtask

  task automatic t_mono();
    aQ = {32'h00AB_CDEF, 32'h0012_3456};
    startTest(3'd1, 1'b1, 1'b0, 1'b0);
    runFrames(2);
    expL[0] = 32'hABCD_EF00; expR[0] = 32'hABCD_EF00;
    expL[1] = 32'h1234_5600; expR[1] = 32'h1234_5600;
    cmpFrames(2, "R6 mono");
    check("R6 right slot takes no word", {31'd0, flagPre}, 32'd0);
  endtask

  task automatic t_perChan();
    aQ = {32'h0000_1111, 32'h0000_3333};
    bQ = {32'h0000_2222, 32'h0000_4444};
    startTest(3'd4, 1'b0, 1'b1, 1'b0);
    runFrames(2);
    expL[0] = 32'h1111_0000; expR[0] = 32'h2222_0000;
    expL[1] = 32'h3333_0000; expR[1] = 32'h4444_0000;
    cmpFrames(2, "R8 per-channel streams");
    check("R8 stream B drained", bQ.size(), 32'd0);
  endtask

  task automatic t_underrun(input logic rep);
    aQ = {32'hA5A5_0F0F, 32'h5A5A_F0F0};
    startTest(3'd0, 1'b0, 1'b0, rep);
    runFrames(2);
    expL[0] = 32'hA5A5_0F0F; expR[0] = 32'h5A5A_F0F0;
    expL[1] = rep ? 32'hA5A5_0F0F : 32'h0;
    expR[1] = rep ? 32'h5A5A_F0F0 : 32'h0;
    cmpFrames(2, rep ? "R10 repeat on underrun" : "R9 zero on underrun");
    check("R11 underrun flag set", {31'd0, flagPre}, 32'd1);
  endtask

  task automatic t_clear();
    @(negedge clk);
    check("R11 flag still set before clear", {31'd0, underrun}, 32'd1);
    clrUnderrun = 1'b1;
    @(negedge clk);
    clrUnderrun = 1'b0;
    check("R11 flag cleared by pulse", {31'd0, underrun}, 32'd0);
  endtask

  task automatic t_disabled();
    aQ = {32'hFFFF_FFFF};
    startTest(3'd0, 1'b0, 1'b0, 1'b0);
    en = 1'b0;
    sawTake = 1'b0;
    for (int k = 0; k < 6; k++) begin
      doTick(k[0]);
      check("R12 sdo low while disabled", {31'd0, sdo}, 32'd0);
    end
    check("R12 no word taken while disabled", {31'd0, sawTake}, 32'd0);
    check("R12 queue untouched", aQ.size(), 32'd1);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_stereo32();
    t_lengths();
    t_pack16();
    t_pack8();
    t_mono();
    t_perChan();
    t_underrun(1'b0);
    t_underrun(1'b1);
    en = 1'b0;
    t_clear();
    t_disabled();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule